// File: doc/BRIEF.md
# Three-Channel Interval Timer Host Register Interface

This block is the processor-facing side of a three-channel programmable interval timer. It sits on an 8-bit bus with a 2-bit address. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port. The counting cores sit outside the block. Each core receives a one-cycle load strobe with a 16-bit start value, and it reports its running count and output level back to this block.

Writes to the control port do one of three things. A configuration word sets a channel's byte access mode and counting mode. A counter-latch word freezes one channel's running count. A read-back word can freeze the count and/or the status of several channels in a single write. Every data write and data read is steered by the channel's access mode: low byte only, high byte only, or a word sent low byte first and high byte second. Each channel holds a frozen status and a frozen count that are consumed by reads. A pending status is always returned before a pending count, and a pending count is returned before the running count.

Top module: `ivt_bus_regs`

## Requirements
- R1: `bus_rdata` is 0 in any cycle where `bus_rd` is low, and also when the control port (address 3) is read. A read of the control port changes no state.
- R2: After reset, every channel is in word access mode with counting mode 0. Both byte pointers are on the first (low) byte, nothing is latched, and `ld_stb` is 0.
- R3: A control write with channel field bits 7:6 = n (n < 3) and access field bits 5:4 != 0 stores bits 5:4 as the access mode and bits 3:1 as the counting mode of channel n. It also returns that channel's write and read byte pointers to the first byte.
- R4: A data write to channel n loads a count as follows. Access 1 loads {8'h00, byte}. Access 2 loads {byte, 8'h00}. Access 3 only holds the first byte, and the second byte loads {second, first}, after which the pointer returns to the first byte.
- R5: A load appears on `ld_stb[n]` for exactly one cycle, starting in the cycle after the data write. `ld_val[16n+15:16n]` carries the value in that cycle. At most one strobe bit is high at a time.
- R6: A control write with bits 7:6 = n and bits 5:4 = 0 freezes channel n's running count together with its access mode. The freeze happens only if no frozen count is pending. A repeated freeze before readout keeps the first value.
- R7: A control write with bits 7:6 = 3 is a read-back. Bit n+1 selects channel n. Bit 5 low freezes the count of each selected channel, and bit 4 low freezes its status. Any number of channels may be selected at once.
- R8: A frozen status byte holds the following: bit 7 = channel output level, bit 6 = 0, bits 5:4 = access mode, bits 3:1 = counting mode, bit 0 = 0.
- R9: A data read returns a pending status first and clears it. A status freeze request while a status is pending is ignored.
- R10: With no status pending, a frozen count is read as follows. Access 1 returns the low byte. Access 2 returns the high byte. Access 3 returns the low byte and then the high byte on the next read. The freeze clears after its last byte. With nothing frozen, reads return the running count with the same byte choice, and access 3 alternates low/high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | 0..2 channel data port, 3 control port |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle `bus_rd` is high |
| ld_stb | output | 3 | Per-channel load strobe to the counting cores |
| ld_val | output | 48 | Load values, channel n in bits 16n+15:16n |
| live_cnt | input | 48 | Running counts from the cores, channel n in bits 16n+15:16n |
| live_out | input | 3 | Output levels from the cores |

## Verification
The properties assume that a bus cycle is either a read or a write and never both. The property that a read clears a pending status excludes cycles where a control write could freeze it again. The bench drives a single access per cycle and follows every access with an idle cycle, so `bus_rd` and `bus_wr` are never high together. The counting cores are modelled in the bench as plain registers that change only between accesses, so every expected count byte is known exactly when the freeze or the read happens.

// File: rtl/ivt_regs_pkg.sv
`timescale 1ns/1ps
package ivt_regs_pkg;
  localparam int CNT_W = 16;
  localparam int BYTE_W = 8;

  // access field: 0 doubles as "nothing latched" in the count latch state
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  function automatic logic [BYTE_W-1:0] ivt_status_byte(input logic out_lvl,
                                                        input acc_e acc,
                                                        input logic [2:0] mode);
    return {out_lvl, 1'b0, acc, mode, 1'b0};
  endfunction

  function automatic logic [CNT_W-1:0] ivt_load_value(input acc_e acc,
                                                      input logic [BYTE_W-1:0] b,
                                                      input logic [BYTE_W-1:0] held);
    case (acc)
      ACC_LO:  return {{BYTE_W{1'b0}}, b};
      ACC_HI:  return {b, {BYTE_W{1'b0}}};
      default: return {b, held};
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] ivt_pick_byte(input logic [CNT_W-1:0] v,
                                                      input logic hi);
    return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/ivt_ctrl_decode.sv
`timescale 1ns/1ps
module ivt_ctrl_decode
  import ivt_regs_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] cword,
  output logic [NCH-1:0]    cfg_stb,
  output logic [NCH-1:0]    cnt_lat_req,
  output logic [NCH-1:0]    stat_lat_req,
  output acc_e              cfg_acc,
  output logic [2:0]        cfg_mode
);
  localparam int SEL_W = 2;

  logic [SEL_W-1:0] sel;
  logic             is_readback;
  logic             no_cnt;
  logic             no_stat;

  assign sel         = cword[7:6];
  assign cfg_acc     = acc_e'(cword[5:4]);
  assign cfg_mode    = cword[3:1];
  assign is_readback = ctrl_wr && (sel == {SEL_W{1'b1}});
  assign no_cnt      = cword[5];
  assign no_stat     = cword[4];

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    logic hit;
    logic rb_pick;
    assign hit             = ctrl_wr && !is_readback && (sel == SEL_W'(n));
    assign rb_pick         = is_readback && cword[n+1];
    assign cfg_stb[n]      = hit && (cfg_acc != ACC_NONE);
    assign cnt_lat_req[n]  = (hit && (cfg_acc == ACC_NONE)) || (rb_pick && !no_cnt);
    assign stat_lat_req[n] = rb_pick && !no_stat;
  end
endmodule

// File: rtl/ivt_chan_regs.sv
`timescale 1ns/1ps
module ivt_chan_regs
  import ivt_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_stb,
  input  acc_e              cfg_acc,
  input  logic [2:0]        cfg_mode,
  input  logic              cnt_lat_req,
  input  logic              stat_lat_req,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              live_out,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              ld_stb,
  output logic [CNT_W-1:0]  ld_val,
  output logic              stat_pend,
  output logic              lat_busy,
  output logic [CNT_W-1:0]  lat_val
);
  acc_e              acc_q;
  logic [2:0]        mode_q;
  logic              wr_hi_q;
  logic              rd_hi_q;
  logic [BYTE_W-1:0] hold_q;
  acc_e              lat_st_q;
  logic [CNT_W-1:0]  lat_val_q;
  logic              stat_pend_q;
  logic [BYTE_W-1:0] stat_q;

  // named events
  logic wr_done;
  logic live_hi;

  assign wr_done   = data_wr && ((acc_q != ACC_WORD) || wr_hi_q);
  assign live_hi   = (acc_q == ACC_HI) || ((acc_q == ACC_WORD) && rd_hi_q);
  assign stat_pend = stat_pend_q;
  assign lat_busy  = (lat_st_q != ACC_NONE);
  assign lat_val   = lat_val_q;

  always_comb begin
    if (stat_pend_q)
      rd_byte = stat_q;
    else if (lat_st_q != ACC_NONE)
      rd_byte = ivt_pick_byte(lat_val_q, lat_st_q == ACC_HI);
    else
      rd_byte = ivt_pick_byte(live_cnt, live_hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q       <= ACC_WORD;
      mode_q      <= '0;
      wr_hi_q     <= 1'b0;
      rd_hi_q     <= 1'b0;
      hold_q      <= '0;
      lat_st_q    <= ACC_NONE;
      lat_val_q   <= '0;
      stat_pend_q <= 1'b0;
      stat_q      <= '0;
      ld_stb      <= 1'b0;
      ld_val      <= '0;
    end else begin
      ld_stb <= wr_done;
      if (wr_done)
        ld_val <= ivt_load_value(acc_q, wdata, hold_q);
      if (data_wr && (acc_q == ACC_WORD)) begin
        if (!wr_hi_q)
          hold_q <= wdata;
        wr_hi_q <= !wr_hi_q;
      end

      if (data_rd) begin
        if (stat_pend_q)
          stat_pend_q <= 1'b0;
        else if (lat_st_q != ACC_NONE)
          lat_st_q <= (lat_st_q == ACC_WORD) ? ACC_HI : ACC_NONE;
        else if (acc_q == ACC_WORD)
          rd_hi_q <= !rd_hi_q;
      end

      if (cnt_lat_req && (lat_st_q == ACC_NONE)) begin
        lat_st_q  <= acc_q;
        lat_val_q <= live_cnt;
      end
      if (stat_lat_req && !stat_pend_q) begin
        stat_pend_q <= 1'b1;
        stat_q      <= ivt_status_byte(live_out, acc_q, mode_q);
      end

      if (cfg_stb) begin
        acc_q   <= cfg_acc;
        mode_q  <= cfg_mode;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ivt_bus_regs.sv
`timescale 1ns/1ps
module ivt_bus_regs
  import ivt_regs_pkg::*;
#(
  parameter  int NCH = 3,
  localparam int AW  = $clog2(NCH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [BYTE_W-1:0]    bus_wdata,
  output logic [BYTE_W-1:0]    bus_rdata,
  output logic [NCH-1:0]       ld_stb,
  output logic [NCH*CNT_W-1:0] ld_val,
  input  logic [NCH*CNT_W-1:0] live_cnt,
  input  logic [NCH-1:0]       live_out
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  logic                            ctrl_hit;
  logic [NCH-1:0]                  cfg_stb;
  logic [NCH-1:0]                  cnt_lat_req;
  logic [NCH-1:0]                  stat_lat_req;
  acc_e                            cfg_acc;
  logic [2:0]                      cfg_mode;
  logic [NCH-1:0][BYTE_W-1:0]      ch_byte;
  // internal events brought out for the checker
  logic [NCH-1:0]                  stat_pend_w;
  logic [NCH-1:0]                  lat_busy_w;
  logic [NCH-1:0][CNT_W-1:0]       lat_val_w;

  assign ctrl_hit = (bus_addr == CTRL_ADDR);

  ivt_ctrl_decode #(.NCH(NCH)) u_dec (
    .ctrl_wr      (bus_wr && ctrl_hit),
    .cword        (bus_wdata),
    .cfg_stb      (cfg_stb),
    .cnt_lat_req  (cnt_lat_req),
    .stat_lat_req (stat_lat_req),
    .cfg_acc      (cfg_acc),
    .cfg_mode     (cfg_mode)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic sel_n;
    assign sel_n = (bus_addr == AW'(n));
    ivt_chan_regs u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_stb      (cfg_stb[n]),
      .cfg_acc      (cfg_acc),
      .cfg_mode     (cfg_mode),
      .cnt_lat_req  (cnt_lat_req[n]),
      .stat_lat_req (stat_lat_req[n]),
      .data_wr      (bus_wr && sel_n),
      .data_rd      (bus_rd && sel_n),
      .wdata        (bus_wdata),
      .live_cnt     (live_cnt[n*CNT_W +: CNT_W]),
      .live_out     (live_out[n]),
      .rd_byte      (ch_byte[n]),
      .ld_stb       (ld_stb[n]),
      .ld_val       (ld_val[n*CNT_W +: CNT_W]),
      .stat_pend    (stat_pend_w[n]),
      .lat_busy     (lat_busy_w[n]),
      .lat_val      (lat_val_w[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && !ctrl_hit) begin
      for (int n = 0; n < NCH; n++)
        if (bus_addr == AW'(n))
          bus_rdata = ch_byte[n];
    end
  end
endmodule

// File: rtl/ivt_bus_regs_chk.sv
`timescale 1ns/1ps
module ivt_bus_regs_chk
  import ivt_regs_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [AW-1:0]              bus_addr,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [BYTE_W-1:0]          bus_rdata,
  input logic [NCH-1:0]             ld_stb,
  input logic [NCH-1:0]             stat_pend_w,
  input logic [NCH-1:0]             lat_busy_w,
  input logic [NCH-1:0][CNT_W-1:0]  lat_val_w
);
  // R1
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || bus_addr == AW'(NCH)) |-> (bus_rdata == '0));

  // R5
  ld_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_stb));

  // R5
  ld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ld_stb) |-> ($past(bus_wr) && ($past(bus_addr) != AW'(NCH))));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == AW'(n) && stat_pend_w[n]) |=> !stat_pend_w[n]);

    // R6
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_busy_w[n] && !(bus_rd && bus_addr == AW'(n)))
        |=> ($stable(lat_val_w[n]) && lat_busy_w[n]));
  end
endmodule

bind ivt_bus_regs ivt_bus_regs_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .ld_stb      (ld_stb),
  .stat_pend_w (stat_pend_w),
  .lat_busy_w  (lat_busy_w),
  .lat_val_w   (lat_val_w)
);

// File: tb/ivt_bus_regs_bench.sv
`timescale 1ns/1ps
module ivt_bus_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [2:0]  ld_stb;
  logic [47:0] ld_val;
  logic [47:0] live_cnt = '0;
  logic [2:0]  live_out = '0;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0]  exp_rd_q[$];
  string       rd_tag_q[$];
  logic [17:0] exp_ld_q[$];
  string       ld_tag_q[$];

  always #5 clk = ~clk;

  ivt_bus_regs u_ivt_bus_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ld_stb(ld_stb), .ld_val(ld_val), .live_cnt(live_cnt), .live_out(live_out)
  );

  task automatic check_eq(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_live(input int ch, input logic [15:0] v);
    live_cnt[ch*16 +: 16] = v;
  endtask

  // one access cycle followed by an idle cycle
  task automatic access(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    access(1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_rd_q.push_back(exp);
    rd_tag_q.push_back(tag);
    access(1'b0, 1'b1, a, 8'h00);
  endtask

  task automatic expect_ld(input int ch, input logic [15:0] v, input string tag);
    exp_ld_q.push_back({2'(ch), v});
    ld_tag_q.push_back(tag);
  endtask

  // write of a first word byte: strobe window must stay quiet
  task automatic wr_no_load(input logic [1:0] a, input logic [7:0] d, input string tag);
    wr(a, d);
    #3;
    check_eq(tag, {29'd0, ld_stb}, 32'd0);
  endtask

  // monitor: compares design results against the scoreboard queues
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (bus_rd) begin
          if (exp_rd_q.size() == 0) begin
            checks++; errs++;
            $display("FAIL R10: unexpected read got %h expected none", bus_rdata);
          end else begin
            logic [7:0] e;
            string t;
            e = exp_rd_q.pop_front();
            t = rd_tag_q.pop_front();
            check_eq(t, {24'd0, bus_rdata}, {24'd0, e});
          end
        end else if (bus_rdata !== 8'h00) begin
          checks++; errs++;
          $display("FAIL R1: idle rdata got %h expected 00", bus_rdata);
        end
        if (|ld_stb) begin
          logic [1:0] ch;
          ch = ld_stb[0] ? 2'd0 : (ld_stb[1] ? 2'd1 : 2'd2);
          if (exp_ld_q.size() == 0) begin
            checks++; errs++;
            $display("FAIL R5: unexpected load got %h expected none", {ch, ld_val[ch*16 +: 16]});
          end else begin
            logic [17:0] e;
            string t;
            e = exp_ld_q.pop_front();
            t = ld_tag_q.pop_front();
            check_eq(t, {14'd0, ch, ld_val[ch*16 +: 16]}, {14'd0, e});
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R2: outputs quiet while in reset
    check_eq("R2 ld_stb in reset", {29'd0, ld_stb}, 32'd0);
    check_eq("R1 rdata in reset", {24'd0, bus_rdata}, 32'd0);
    rst_n = 1'b1;
    set_live(0, 16'h1234);

    // R2: word mode after reset, low byte first
    rd(2'd0, 8'h34, "R2 word low");
    rd(2'd0, 8'h12, "R2 word high");
    // R2/R8: status after reset: access 3, mode 0, out 0
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'h30, "R8 reset status");
    rd(2'd0, 8'h34, "R2 pointer back to low");
    // R1: control port reads zero
    rd(2'd3, 8'h00, "R1 control read");

    // R3/R4: low-only, high-only, word loads
    wr(2'd3, 8'h14);
    expect_ld(0, 16'h00A5, "R4 low-only load");
    wr(2'd0, 8'hA5);
    wr(2'd3, 8'h66);
    expect_ld(1, 16'h3C00, "R4 high-only load");
    wr(2'd1, 8'h3C);
    wr(2'd3, 8'hB8);
    wr_no_load(2'd2, 8'h11, "R4 first byte holds");
    expect_ld(2, 16'h2211, "R4 word load");
    wr(2'd2, 8'h22);
    wr_no_load(2'd2, 8'h33, "R4 pointer returned");
    expect_ld(2, 16'h4433, "R4 second word load");
    wr(2'd2, 8'h44);

    // R10: running count reads per access mode
    set_live(1, 16'hBEEF);
    rd(2'd1, 8'hBE, "R10 live high-only");
    rd(2'd1, 8'hBE, "R10 live high-only repeat");
    set_live(0, 16'h5678);
    rd(2'd0, 8'h78, "R10 live low-only");
    rd(2'd0, 8'h78, "R10 live low-only repeat");

    // R6: counter latch, repeat ignored
    set_live(2, 16'hCAFE);
    wr(2'd3, 8'h80);
    set_live(2, 16'h0101);
    wr(2'd3, 8'h80);
    rd(2'd2, 8'hFE, "R6 latched low");
    rd(2'd2, 8'hCA, "R6 latched high");
    rd(2'd2, 8'h01, "R10 latch cleared low");
    rd(2'd2, 8'h01, "R10 latch cleared high");

    // R7/R8: status-only read-back of channel 2
    live_out = 3'b100;
    wr(2'd3, 8'hE8);
    rd(2'd2, 8'hB8, "R8 status byte");

    // R9: status before count, channel 0 low-only
    live_out = 3'b000;
    wr(2'd3, 8'hC2);
    set_live(0, 16'h9999);
    rd(2'd0, 8'h14, "R9 status first");
    rd(2'd0, 8'h78, "R10 latched low-only");
    rd(2'd0, 8'h99, "R10 low-only latch cleared");

    // R9: both on channel 2 (word)
    set_live(2, 16'h9ABC);
    wr(2'd3, 8'hC8);
    set_live(2, 16'h0000);
    rd(2'd2, 8'h38, "R9 status before count");
    rd(2'd2, 8'hBC, "R10 latched word low");
    rd(2'd2, 8'h9A, "R10 latched word high");
    rd(2'd2, 8'h00, "R10 live after latch");

    // R9: second status latch ignored while pending
    live_out = 3'b010;
    wr(2'd3, 8'hE4);
    live_out = 3'b000;
    wr(2'd3, 8'hE4);
    rd(2'd1, 8'hA6, "R9 first status kept");
    rd(2'd1, 8'hBE, "R9 no second status");

    // R7: count read-back of all three channels at once
    set_live(0, 16'h0A0B);
    set_live(1, 16'h1C1D);
    set_live(2, 16'h2E2F);
    wr(2'd3, 8'hDE);
    set_live(0, 16'hFFFF);
    set_live(1, 16'hFFFF);
    set_live(2, 16'h4321);
    rd(2'd0, 8'h0B, "R7 multi ch0");
    rd(2'd1, 8'h1C, "R7 multi ch1");
    rd(2'd2, 8'h2F, "R7 multi ch2 low");
    rd(2'd2, 8'h2E, "R7 multi ch2 high");

    // R3: reconfiguration restarts both byte pointers
    rd(2'd2, 8'h43, "R10 live pointer on high");
    wr_no_load(2'd2, 8'h55, "R3 pending first byte");
    wr(2'd3, 8'hB8);
    rd(2'd2, 8'h21, "R3 read pointer restart");
    wr_no_load(2'd2, 8'h66, "R3 write pointer restart");
    expect_ld(2, 16'h7766, "R3 word after restart");
    wr(2'd2, 8'h77);

    repeat (3) @(posedge clk);
    #2;
    while (exp_rd_q.size() > 0) begin
      checks++; errs++;
      $display("FAIL R10: missing read got none expected %h", exp_rd_q.pop_front());
    end
    while (exp_ld_q.size() > 0) begin
      checks++; errs++;
      $display("FAIL R5: missing load got none expected %h", exp_ld_q.pop_front());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule